// File: doc/BRIEF.md
# GPIO Transition Interrupt and Global Configuration Controller

This block sits inside a small register-mapped GPIO expander. It holds the expander's global configuration register and watches an 8-bit bank of general-purpose inputs. When an input whose interrupt enable bit is set changes level, in either direction, the block latches a pending bit and drives the interrupt line. The line can be a level that stays up until software clears the pending bits, or a fixed-length pulse, with either polarity. The same register gives a low-power request with automatic wake on an input event, a one-shot software reset, and two reset-mask bits that protect the two GPIO register groups from the hardware reset.

Three address strap inputs are captured while the hardware reset is held and are then kept for the device address. Two resets exist. The power-on reset clears everything. The hardware reset clears everything except the two reset-mask bits and the captured straps, which are sampled during it. Both resets assert asynchronously and are released through a two-stage synchronizer.

Top module: `gpx_cfg_irq`

## Requirements
- R1: After power-on reset the configuration (0x22), enable (0x06) and pending (0x07) registers read 0x00, the low-power output is 0, the mask outputs are 00, and the interrupt line idles high.
- R2: A hardware reset clears configuration bits 5..2, the enable register and the pending register. It keeps configuration bits 1 and 0, which drive mask outputs [1] and [0]. A power-on reset clears those two bits as well.
- R3: A write to 0x22 with bit 7 set gives a single-cycle high on the software reset output in the cycle after the write. Bit 7 always reads as 0.
- R4: Configuration bit 6 ignores writes and always reads as 0.
- R5: A rising or falling transition on input i with enable bit i set sets pending bit i at the next clock edge. A transition on an input whose enable bit is clear changes neither the pending register nor the interrupt line.
- R6: Writing 1s to 0x07 clears the matching pending bits. If a new transition arrives on the same bit in the same cycle, the set wins.
- R7: With bit 2 clear (level style), the interrupt is active for as long as any pending bit is set.
- R8: With bit 2 set (pulse style), each enabled transition makes the interrupt active for exactly 4 cycles, starting the cycle after the transition. A new transition during a pulse restarts the 4-cycle count.
- R9: With bit 3 clear the interrupt is active low. With bit 3 set it is active high.
- R10: Bit 5 drives the low-power output. While it is set, pulse-style interrupts are suppressed, but transitions are still detected into the pending register.
- R11: If bit 4 (wake enable) and bit 5 are both set, an enabled transition clears bit 5 at the same edge that sets the pending bit. A transition on a disabled input does not.
- R12: The device address output takes the strap inputs as they are while the hardware reset is held, and holds that value until the next hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low |
| rst_n | input | 1 | Hardware reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| gpi_in | input | 8 | General-purpose inputs, synchronous to clk |
| strap_in | input | 3 | Address strap inputs |
| irq_o | output | 1 | Interrupt line |
| lowpwr_o | output | 1 | Low-power / clock-gate request |
| sw_rst_o | output | 1 | Software reset pulse |
| grp_rst_mask_o | output | 2 | Reset masks for GPIO groups B [1] and A [0] |
| dev_addr_o | output | 3 | Captured device address bits |

## Verification
The bench toggles an input in both directions and checks that an enabled edge sets pending one edge later, while a disabled one leaves both the pending register and the line alone. A detector that only saw rising edges, or that ignored the enables, would fail here. Pulse length is counted cycle by cycle, both for a single pulse and for a retriggered one, which catches counters that are off by one or that do not reload. A write-1-to-clear in the same cycle as a new edge checks that the set wins. The bench also checks that low power suppresses pulses without losing the pending status and that only an enabled edge wakes the block. A hardware reset must keep the masks and take the new straps, while a power-on reset must clear the masks. A design that mixed up the two reset domains would fail these checks.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int CFG_SWRST = 7;
  localparam int CFG_RSVD  = 6;
  localparam int CFG_LP    = 5;
  localparam int CFG_WAKE  = 4;
  localparam int CFG_POL   = 3;
  localparam int CFG_PULSE = 2;
  localparam int CFG_MSKB  = 1;
  localparam int CFG_MSKA  = 0;

  // configuration bits cleared by the hardware reset
  typedef struct packed {
    logic lp;
    logic wake;
    logic pol;
    logic pulse;
  } cfg_hw_t;
endpackage

// File: rtl/gpx_rst_sync.sv
module gpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic sync_rn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign sync_rn = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_cfg_reg.sv
module gpx_cfg_reg
  import gpx_pkg::*;
(
  input  logic       clk,
  input  logic       por_rn,
  input  logic       hw_rn,
  input  logic       wr_en,
  input  logic       sw_bit,
  input  logic [3:0] hw_bits,
  input  logic [1:0] mask_bits,
  input  logic       wake_evt,
  output cfg_hw_t    cfg_o,
  output logic [1:0] mask_o,
  output logic       sw_rst_o
);
  cfg_hw_t    cfg_q, cfg_d;
  logic [1:0] mask_q, mask_d;
  logic       swr_q, swr_d;
  logic       wake_clr;

  // a wake event beats a write to the low-power bit in the same cycle
  assign wake_clr = cfg_q.wake && cfg_q.lp && wake_evt;

  always_comb begin
    cfg_d  = cfg_q;
    mask_d = mask_q;
    swr_d  = wr_en && sw_bit;
    if (wr_en) begin
      cfg_d.lp    = hw_bits[3];
      cfg_d.wake  = hw_bits[2];
      cfg_d.pol   = hw_bits[1];
      cfg_d.pulse = hw_bits[0];
      mask_d      = mask_bits;
    end
    if (wake_clr) cfg_d.lp = 1'b0;
  end

  always_ff @(posedge clk or negedge hw_rn) begin
    if (!hw_rn) begin
      cfg_q <= '0;
      swr_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      swr_q <= swr_d;
    end
  end

  // masks only see the power-on reset
  always_ff @(posedge clk or negedge por_rn) begin
    if (!por_rn) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign cfg_o    = cfg_q;
  assign mask_o   = mask_q;
  assign sw_rst_o = swr_q;
endmodule

// File: rtl/gpx_edge_det.sv
module gpx_edge_det #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             hw_rn,
  input  logic [WIDTH-1:0] gpi,
  input  logic             ien_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] ien_o,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] edge_o,
  output logic             evt_o
);
  logic [WIDTH-1:0] gpi_q, ien_q, ien_d, pend_q, pend_d, edge_v;
  logic             armed_q;

  // no edge is reported until the copy holds a real sample
  assign edge_v = armed_q ? ((gpi ^ gpi_q) & ien_q) : '0;

  always_comb begin
    ien_d  = ien_we ? wdata : ien_q;
    pend_d = pend_q;
    for (int i = 0; i < WIDTH; i++) begin
      if (clr_we && wdata[i]) pend_d[i] = 1'b0;
      if (edge_v[i])          pend_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge hw_rn) begin
    if (!hw_rn) begin
      gpi_q   <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      gpi_q   <= gpi;
      ien_q   <= ien_d;
      pend_q  <= pend_d;
      armed_q <= 1'b1;
    end
  end

  assign ien_o  = ien_q;
  assign pend_o = pend_q;
  assign edge_o = edge_v;
  assign evt_o  = |edge_v;
endmodule

// File: rtl/gpx_irq_out.sv
module gpx_irq_out #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic hw_rn,
  input  logic evt,
  input  logic pend_any,
  input  logic pulse_mode,
  input  logic active_high,
  input  logic lowpwr,
  output logic irq_act,
  output logic irq_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_ok;

  assign pulse_ok = pulse_mode && !lowpwr;

  always_comb begin
    if (!pulse_ok)           cnt_d = '0;
    else if (evt)            cnt_d = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge hw_rn) begin
    if (!hw_rn) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign irq_act = pulse_mode ? (pulse_ok && (cnt_q != '0)) : pend_any;
  assign irq_o   = active_high ? irq_act : !irq_act;
endmodule

// File: rtl/gpx_cfg_irq.sv
module gpx_cfg_irq
  import gpx_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter int          STRAP_W   = 3,
  parameter int          PULSE_LEN = 4,
  parameter int          SYNC_LEN  = 2,
  parameter logic [7:0]  CFG_ADDR  = 8'h22,
  parameter logic [7:0]  IEN_ADDR  = 8'h06,
  parameter logic [7:0]  PEND_ADDR = 8'h07
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] gpi_in,
  input  logic [STRAP_W-1:0] strap_in,
  output logic              irq_o,
  output logic              lowpwr_o,
  output logic              sw_rst_o,
  output logic [1:0]        grp_rst_mask_o,
  output logic [STRAP_W-1:0] dev_addr_o
);
  logic              por_rn, hw_rn, hw_raw_n;
  logic              cfg_sel, ien_sel, pend_sel;
  cfg_hw_t           cfg_q;
  logic [1:0]        mask_q;
  logic [DATA_W-1:0] ien_q, pend_q, edge_vec;
  logic              evt_any, irq_act;
  logic              cfg_pulse, cfg_wake;
  logic [STRAP_W-1:0] strap_q;
  logic [DATA_W-1:0] cfg_rd;

  assign hw_raw_n = por_n && rst_n;

  gpx_rst_sync #(.STAGES(SYNC_LEN)) u_por_sync (
    .clk(clk), .arst_n(por_n), .sync_rn(por_rn));
  gpx_rst_sync #(.STAGES(SYNC_LEN)) u_hw_sync (
    .clk(clk), .arst_n(hw_raw_n), .sync_rn(hw_rn));

  assign cfg_sel  = (reg_addr == ADDR_W'(CFG_ADDR));
  assign ien_sel  = (reg_addr == ADDR_W'(IEN_ADDR));
  assign pend_sel = (reg_addr == ADDR_W'(PEND_ADDR));

  gpx_cfg_reg u_cfg (
    .clk      (clk),
    .por_rn   (por_rn),
    .hw_rn    (hw_rn),
    .wr_en    (reg_we && cfg_sel),
    .sw_bit   (reg_wdata[CFG_SWRST]),
    .hw_bits  (reg_wdata[CFG_LP:CFG_PULSE]),
    .mask_bits(reg_wdata[CFG_MSKB:CFG_MSKA]),
    .wake_evt (evt_any),
    .cfg_o    (cfg_q),
    .mask_o   (mask_q),
    .sw_rst_o (sw_rst_o)
  );

  gpx_edge_det #(.WIDTH(DATA_W)) u_edge (
    .clk   (clk),
    .hw_rn (hw_rn),
    .gpi   (gpi_in),
    .ien_we(reg_we && ien_sel),
    .clr_we(reg_we && pend_sel),
    .wdata (reg_wdata),
    .ien_o (ien_q),
    .pend_o(pend_q),
    .edge_o(edge_vec),
    .evt_o (evt_any)
  );

  assign cfg_pulse = cfg_q.pulse;
  assign cfg_wake  = cfg_q.wake;

  gpx_irq_out #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk        (clk),
    .hw_rn      (hw_rn),
    .evt        (evt_any),
    .pend_any   (|pend_q),
    .pulse_mode (cfg_pulse),
    .active_high(cfg_q.pol),
    .lowpwr     (cfg_q.lp),
    .irq_act    (irq_act),
    .irq_o      (irq_o)
  );

  // straps follow the pins while the hardware reset is held
  always_ff @(posedge clk) begin
    if (!hw_rn) strap_q <= strap_in;
  end

  always_comb begin
    cfg_rd                        = '0;
    cfg_rd[CFG_LP]                = cfg_q.lp;
    cfg_rd[CFG_WAKE]              = cfg_q.wake;
    cfg_rd[CFG_POL]               = cfg_q.pol;
    cfg_rd[CFG_PULSE]             = cfg_q.pulse;
    cfg_rd[CFG_MSKB:CFG_MSKA]     = mask_q;
  end

  always_comb begin
    if (cfg_sel)       reg_rdata = cfg_rd;
    else if (ien_sel)  reg_rdata = ien_q;
    else if (pend_sel) reg_rdata = pend_q;
    else               reg_rdata = '0;
  end

  assign lowpwr_o       = cfg_q.lp;
  assign grp_rst_mask_o = mask_q;
  assign dev_addr_o     = strap_q;
endmodule

// File: rtl/gpx_cfg_irq_chk.sv
module gpx_cfg_irq_chk #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         STRAP_W  = 3,
  parameter logic [7:0] CFG_ADDR = 8'h22
) (
  input logic               clk,
  input logic               hw_rn,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               sw_rst_o,
  input logic               lowpwr_o,
  input logic               pulse_mode,
  input logic               wake_en,
  input logic               evt_any,
  input logic [DATA_W-1:0]  edge_vec,
  input logic [DATA_W-1:0]  pend_q,
  input logic               irq_act,
  input logic [STRAP_W-1:0] dev_addr_o
);
  // R3
  swrst_cause_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    sw_rst_o |-> $past(reg_we && reg_addr == ADDR_W'(CFG_ADDR) && reg_wdata[7]));

  // R4
  cfg_hibits_zero_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    (reg_addr == ADDR_W'(CFG_ADDR)) |-> (reg_rdata[7:6] == 2'b00));

  // R5
  pend_needs_edge_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    ((pend_q & ~$past(pend_q)) != '0) |-> ($past(edge_vec) != '0));

  // R7
  level_follows_pend_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    (!pulse_mode && pend_q != '0) |-> irq_act);

  // R8
  pulse_starts_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    (pulse_mode && !lowpwr_o && evt_any) |=> (irq_act || !pulse_mode || lowpwr_o));

  // R10
  lp_quiet_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    (lowpwr_o && $past(lowpwr_o) && pulse_mode) |-> !irq_act);

  // R11
  wake_clears_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    (wake_en && lowpwr_o && evt_any) |=> !lowpwr_o);

  // R12
  strap_hold_chk: assert property (@(posedge clk) disable iff (!hw_rn)
    $past(hw_rn) |-> $stable(dev_addr_o));
endmodule

bind gpx_cfg_irq gpx_cfg_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W), .CFG_ADDR(CFG_ADDR)
) chk_i (
  .clk       (clk),
  .hw_rn     (hw_rn),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .sw_rst_o  (sw_rst_o),
  .lowpwr_o  (lowpwr_o),
  .pulse_mode(cfg_pulse),
  .wake_en   (cfg_wake),
  .evt_any   (evt_any),
  .edge_vec  (edge_vec),
  .pend_q    (pend_q),
  .irq_act   (irq_act),
  .dev_addr_o(dev_addr_o)
);

// File: tb/gpx_cfg_irq_tb_top.sv
module gpx_cfg_irq_tb_top;
  localparam logic [7:0] A_CFG  = 8'h22;
  localparam logic [7:0] A_IEN  = 8'h06;
  localparam logic [7:0] A_PEND = 8'h07;
  localparam int S_RD = 0, S_IRQ = 1, S_LP = 2, S_SW = 3, S_MSK = 4, S_ADR = 5;

  logic       clk;
  logic       por_n, rst_n, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata, gpi_in;
  logic [2:0] strap_in, dev_addr_o;
  logic       irq_o, lowpwr_o, sw_rst_o;
  logic [1:0] grp_rst_mask_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  gpx_cfg_irq dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .gpi_in(gpi_in), .strap_in(strap_in),
    .irq_o(irq_o), .lowpwr_o(lowpwr_o), .sw_rst_o(sw_rst_o),
    .grp_rst_mask_o(grp_rst_mask_o), .dev_addr_o(dev_addr_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      S_RD:    return reg_rdata;
      S_IRQ:   return {7'd0, irq_o};
      S_LP:    return {7'd0, lowpwr_o};
      S_SW:    return {7'd0, sw_rst_o};
      S_MSK:   return {6'd0, grp_rst_mask_o};
      default: return {5'd0, dev_addr_o};
    endcase
  endfunction

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    reg_addr = a;
    expect_out(req, S_RD, exp);
    step();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; reg_we = 1'b0;
    reg_addr = 8'h00; reg_wdata = 8'h00; gpi_in = 8'h00; strap_in = 3'b101;
    repeat (4) step();
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state, R12 strap capture
    expect_out("R1", S_IRQ, 8'h01);
    expect_out("R1", S_LP, 8'h00);
    expect_out("R1", S_SW, 8'h00);
    expect_out("R1", S_MSK, 8'h00);
    expect_out("R12", S_ADR, 8'h05);
    rd_chk(A_CFG, 8'h00, "R1");
    rd_chk(A_IEN, 8'h00, "R1");
    rd_chk(A_PEND, 8'h00, "R1");
    strap_in = 3'b000;
    repeat (2) step();
    expect_out("R12", S_ADR, 8'h05);

    // R3 software reset pulse, R4 reserved bit
    wr(A_CFG, 8'hC0);
    expect_out("R3", S_SW, 8'h01);
    step();
    expect_out("R3", S_SW, 8'h00);
    rd_chk(A_CFG, 8'h00, "R4");

    // R5 disabled input ignored
    wr(A_IEN, 8'h0F);
    gpi_in[7] = 1'b1;
    repeat (2) step();
    expect_out("R5", S_IRQ, 8'h01);
    rd_chk(A_PEND, 8'h00, "R5");

    // R5 rising edge, R7 level hold
    gpi_in[0] = 1'b1;
    expect_out("R7", S_IRQ, 8'h01);
    step();
    expect_out("R7", S_IRQ, 8'h00);
    repeat (3) step();
    expect_out("R7", S_IRQ, 8'h00);
    rd_chk(A_PEND, 8'h01, "R5");
    wr(A_PEND, 8'h01);
    expect_out("R6", S_IRQ, 8'h01);
    rd_chk(A_PEND, 8'h00, "R6");

    // R5 falling edge
    gpi_in[0] = 1'b0;
    step();
    rd_chk(A_PEND, 8'h01, "R5");
    wr(A_PEND, 8'hFF);

    // R6 set beats clear in the same cycle
    gpi_in[1] = 1'b1;
    wr(A_PEND, 8'h02);
    rd_chk(A_PEND, 8'h02, "R6");
    wr(A_PEND, 8'hFF);

    // R9 active-high polarity
    wr(A_CFG, 8'h08);
    expect_out("R9", S_IRQ, 8'h00);
    gpi_in[2] = 1'b1;
    step();
    expect_out("R9", S_IRQ, 8'h01);
    wr(A_PEND, 8'hFF);
    expect_out("R9", S_IRQ, 8'h00);

    // R8 pulse of exactly four cycles
    wr(A_CFG, 8'h04);
    gpi_in[3] = 1'b1;
    expect_out("R8", S_IRQ, 8'h01);
    for (int i = 0; i < 4; i++) begin
      step();
      expect_out("R8", S_IRQ, 8'h00);
    end
    step();
    expect_out("R8", S_IRQ, 8'h01);

    // R8 retrigger restarts the count
    gpi_in[3] = 1'b0;
    step();
    step();
    expect_out("R8", S_IRQ, 8'h00);
    gpi_in[3] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      expect_out("R8", S_IRQ, 8'h00);
    end
    step();
    expect_out("R8", S_IRQ, 8'h01);
    wr(A_PEND, 8'hFF);

    // R10 low power suppresses pulses, detection continues
    wr(A_CFG, 8'h24);
    expect_out("R10", S_LP, 8'h01);
    step();
    gpi_in[2] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      expect_out("R10", S_IRQ, 8'h01);
    end
    rd_chk(A_PEND, 8'h04, "R10");
    expect_out("R10", S_LP, 8'h01);
    wr(A_PEND, 8'hFF);

    // R11 wake only on an enabled edge
    wr(A_CFG, 8'h30);
    gpi_in[6] = 1'b1;
    repeat (3) step();
    expect_out("R11", S_LP, 8'h01);
    gpi_in[1] = 1'b0;
    step();
    expect_out("R11", S_LP, 8'h00);
    expect_out("R11", S_IRQ, 8'h00);
    rd_chk(A_CFG, 8'h10, "R11");
    wr(A_PEND, 8'hFF);

    // R2 hardware reset keeps masks, R12 new straps
    wr(A_CFG, 8'h2F);
    expect_out("R2", S_MSK, 8'h03);
    strap_in = 3'b010;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    strap_in = 3'b111;
    expect_out("R2", S_MSK, 8'h03);
    expect_out("R2", S_LP, 8'h00);
    expect_out("R2", S_IRQ, 8'h01);
    expect_out("R12", S_ADR, 8'h02);
    rd_chk(A_CFG, 8'h03, "R2");
    rd_chk(A_IEN, 8'h00, "R2");
    rd_chk(A_PEND, 8'h00, "R2");

    // R2 power-on reset clears masks
    por_n = 1'b0;
    repeat (3) step();
    por_n = 1'b1;
    repeat (4) step();
    expect_out("R2", S_MSK, 8'h00);
    rd_chk(A_CFG, 8'h00, "R1");

    step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule